// File: doc/BRIEF.md
# Triggered Event Fragment Merger

The block builds one output record for every level-1 accept. Accepts arrive on a small push port with an event buffer number and a set of trigger bits. Both go into two parallel queues that share one push and one pop. A control machine takes the oldest pending accept. It then reads exactly one fragment from each input word stream, starting at input 0 and going up in index order. The record it emits holds a leading identity word, the forwarded fragment words, and a closing word with a word count and two error flags.

Each input stream is the read side of an external receiver FIFO. The block presents a read strobe and looks at the current head word, its valid flag and its end-of-fragment flag. The first word of every fragment carries a buffer number in its low bits. The block compares that number with the number of the accept being served. A disagreement is recorded but the data is still passed on. A fragment that runs to a programmable word limit without an end flag is cut off at that limit and reported. When the output sink stalls, every read stops. When the accept queue is full, a busy flag tells the trigger source to hold off.

Top module: `frag_merger`

## Requirements
- R1: Each record is, in this order: one identity word, the fragment of input 0, then the fragments of inputs 1 to N_IN-1 in ascending order, then one closing word. `out_last_o` is high on the closing word only. At most one input read strobe is high in any cycle.
- R2: Layout of the identity word: bits [BUF_W-1:0] hold the accept's buffer number, bits [16+TRIG_W-1:16] hold its trigger bits, and every other bit is zero.
- R3: Layout of the closing word: bits [CNT_W-1:0] hold the number of fragment words forwarded in the record, not counting the identity and closing words. Bit 31 is the timeout flag and bit 30 is the mismatch flag. All other bits are zero.
- R4: A fragment ends with the word that has its end-of-fragment flag set. The block reads no further word from that input while serving the same accept, so words of later events stay in that input's FIFO.
- R5: When a fragment's first word has low BUF_W bits that differ from the accept's buffer number, closing-word bit 30 is set and `mismatch_o` goes high. `mismatch_o` stays high until reset. The mismatching fragment is still forwarded unchanged.
- R6: A fragment whose `word_limit_i`-th word (limit at least 1) has no end flag is cut off after that word. The closing word then has bit 31 set. A fragment that ends exactly on the limit word is not a timeout.
- R7: While `out_ready_i` is low, no input is read, and a presented output word keeps its value.
- R8: `busy_o` is high exactly when Q_DEPTH accepts are pending. An accept pushed while `busy_o` is high is dropped and produces no record.
- R9: Records come out in the order the accepts were taken. A record is finished before the next one starts. No output word is presented while no accept is pending.
- R10: After reset `out_valid_o`, `busy_o`, `mismatch_o` and all read strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1a_valid_i | input | 1 | Push one accept |
| l1a_buf_i | input | BUF_W | Event buffer number of the accept |
| l1a_trig_i | input | TRIG_W | Trigger bits of the accept |
| busy_o | output | 1 | Accept queue full |
| in_valid_i | input | N_IN | Input FIFO i has a head word |
| in_data_i | input | N_IN*32 | Head words, input i at bits [32i+31:32i] |
| in_last_i | input | N_IN | Head word of input i ends its fragment |
| in_rd_o | output | N_IN | Read strobe, pops head word of input i |
| word_limit_i | input | LIM_W | Maximum fragment length in words |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output word |
| out_last_o | output | 1 | Closing word of a record |
| out_ready_i | input | 1 | Sink accepts the output word |
| mismatch_o | output | 1 | Sticky buffer-number mismatch seen |

## Verification
The bench uses the defaults: three inputs, 2-bit buffer numbers, 8-bit trigger bits and a queue depth of 4. With a depth of 4, the queue can be filled, the full flag observed, and a fifth accept dropped while four records are pending. Fragments for several events are loaded into the input streams ahead of time to show that fragment boundaries are respected. With an 8-bit word limit, the bench can move the limit from 8 down to 3. This covers a fragment longer than the limit, one that ends exactly on it, and single-word fragments in the same record.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int WORD_W = 32;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_FRAG, ST_TRL} fm_state_e;
endpackage

// File: rtl/fm_fifo.sv
module fm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem[rp];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end
endmodule

// File: rtl/fm_in_mux.sv
module fm_in_mux #(
  parameter int N     = 3,
  parameter int W     = 32,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N*W-1:0]   data_i,
  input  logic [N-1:0]     last_i,
  input  logic             rd_en_i,
  output logic             valid_o,
  output logic [W-1:0]     data_o,
  output logic             last_o,
  output logic [N-1:0]     rd_o
);
  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    last_o  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel_i == SEL_W'(i)) begin
        valid_o = valid_i[i];
        data_o  = data_i[i*W +: W];
        last_o  = last_i[i];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rd
    assign rd_o[g] = rd_en_i && (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/frag_merger.sv
module frag_merger
  import fm_pkg::*;
#(
  parameter int N_IN    = 3,
  parameter int BUF_W   = 2,
  parameter int TRIG_W  = 8,
  parameter int Q_DEPTH = 4,
  parameter int LIM_W   = 8,
  parameter int CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     l1a_valid_i,
  input  logic [BUF_W-1:0]         l1a_buf_i,
  input  logic [TRIG_W-1:0]        l1a_trig_i,
  output logic                     busy_o,
  input  logic [N_IN-1:0]          in_valid_i,
  input  logic [N_IN*WORD_W-1:0]   in_data_i,
  input  logic [N_IN-1:0]          in_last_i,
  output logic [N_IN-1:0]          in_rd_o,
  input  logic [LIM_W-1:0]         word_limit_i,
  output logic                     out_valid_o,
  output logic [WORD_W-1:0]        out_data_o,
  output logic                     out_last_o,
  input  logic                     out_ready_i,
  output logic                     mismatch_o
);
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  fm_state_e          st;
  logic [SEL_W-1:0]   sel;
  logic [LIM_W-1:0]   frag_cnt;
  logic [CNT_W-1:0]   tot_cnt;
  logic               err_mm, err_to, mm_sticky;

  logic [BUF_W-1:0]   acc_buf;
  logic [TRIG_W-1:0]  acc_trig;
  logic               acc_full, acc_empty, trg_full, trg_empty, acc_pop;

  logic               m_valid, m_last, rd_en;
  logic [WORD_W-1:0]  m_data, hdr_w, trl_w;
  logic               mm_w, hit_lim, frag_end, last_sel;

  // Accept queue and trigger-bit queue advance in lock step
  fm_fifo #(.W(BUF_W), .DEPTH(Q_DEPTH)) u_acc_q (
    .clk_i, .rst_ni, .push_i(l1a_valid_i), .din_i(l1a_buf_i), .pop_i(acc_pop),
    .dout_o(acc_buf), .full_o(acc_full), .empty_o(acc_empty)
  );

  fm_fifo #(.W(TRIG_W), .DEPTH(Q_DEPTH)) u_trg_q (
    .clk_i, .rst_ni, .push_i(l1a_valid_i), .din_i(l1a_trig_i), .pop_i(acc_pop),
    .dout_o(acc_trig), .full_o(trg_full), .empty_o(trg_empty)
  );

  fm_in_mux #(.N(N_IN), .W(WORD_W), .SEL_W(SEL_W)) u_mux (
    .sel_i(sel), .valid_i(in_valid_i), .data_i(in_data_i), .last_i(in_last_i),
    .rd_en_i(rd_en), .valid_o(m_valid), .data_o(m_data), .last_o(m_last),
    .rd_o(in_rd_o)
  );

  assign busy_o     = acc_full | trg_full;
  assign mismatch_o = mm_sticky;
  assign acc_pop    = (st == ST_TRL) && out_ready_i;
  assign rd_en      = (st == ST_FRAG) && out_ready_i && m_valid;
  assign mm_w       = (frag_cnt == '0) && (m_data[BUF_W-1:0] != acc_buf);
  assign hit_lim    = ({1'b0, frag_cnt} + (LIM_W+1)'(1)) == {1'b0, word_limit_i};
  assign frag_end   = m_last | hit_lim;
  assign last_sel   = (sel == SEL_W'(N_IN - 1));

  always_comb begin
    hdr_w = '0;
    hdr_w[BUF_W-1:0]   = acc_buf;
    hdr_w[16 +: TRIG_W] = acc_trig;
    trl_w = '0;
    trl_w[CNT_W-1:0] = tot_cnt;
    trl_w[30]        = err_mm;
    trl_w[31]        = err_to;
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_last_o  = 1'b0;
    unique case (st)
      ST_HDR:  begin out_valid_o = 1'b1;    out_data_o = hdr_w; end
      ST_FRAG: begin out_valid_o = m_valid; out_data_o = m_data; end
      ST_TRL:  begin out_valid_o = 1'b1;    out_data_o = trl_w; out_last_o = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      sel      <= '0;
      frag_cnt <= '0;
      tot_cnt  <= '0;
      err_mm   <= 1'b0;
      err_to   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          sel      <= '0;
          frag_cnt <= '0;
          tot_cnt  <= '0;
          err_mm   <= 1'b0;
          err_to   <= 1'b0;
          if (!acc_empty && !trg_empty) st <= ST_HDR;
        end
        ST_HDR: if (out_ready_i) st <= ST_FRAG;
        ST_FRAG: if (rd_en) begin
          tot_cnt <= tot_cnt + 1'b1;
          if (mm_w) err_mm <= 1'b1;
          if (frag_end) begin
            frag_cnt <= '0;
            if (!m_last) err_to <= 1'b1;
            if (last_sel) st  <= ST_TRL;
            else          sel <= sel + 1'b1;
          end else begin
            frag_cnt <= frag_cnt + 1'b1;
          end
        end
        ST_TRL: if (out_ready_i) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mm_sticky <= 1'b0;
    else if (rd_en && mm_w)   mm_sticky <= 1'b1;
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int N_IN    = 3,
  parameter int Q_DEPTH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l1a_valid_i,
  input logic              busy_o,
  input logic [N_IN-1:0]   in_rd_o,
  input logic              out_valid_o,
  input logic [31:0]       out_data_o,
  input logic              out_last_o,
  input logic              out_ready_i,
  input logic              mismatch_o
);
  localparam int PW = $clog2(Q_DEPTH + 1) + 1;
  logic [PW-1:0] pend;

  // Independent count of pending accepts seen at the ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend <= '0;
    else pend <= pend + PW'(l1a_valid_i && !busy_o)
                      - PW'(out_valid_o && out_ready_i && out_last_o);
  end

  assert_one_reader_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_rd_o));

  assert_read_needs_sink_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_rd_o) |-> (out_valid_o && out_ready_i));

  assert_closing_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o && !out_ready_i) |=>
      (out_valid_o && out_last_o && $stable(out_data_o)));

  assert_busy_depth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (pend == PW'(Q_DEPTH)));

  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> mismatch_o);

  assert_no_idle_output_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (pend != '0));
endmodule

bind frag_merger fm_checker #(.N_IN(N_IN), .Q_DEPTH(Q_DEPTH)) u_fm_checker (.*);

// File: tb/frag_merger_bench.sv
module frag_merger_bench;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l1a_valid = 1'b0;
  logic [1:0]  l1a_buf = '0;
  logic [7:0]  l1a_trig = '0;
  logic        busy;
  logic [N-1:0]    in_valid, in_last, in_rd;
  logic [N*32-1:0] in_data;
  logic [7:0]  word_limit = 8'd8;
  logic        out_valid, out_last, mismatch;
  logic [31:0] out_data;
  logic        out_ready = 1'b1;
  logic        bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int checks = 0, errors = 0;

  logic [31:0] fmem  [N][512];
  logic        flast [N][512];
  int          head [N];
  int          tail [N];

  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  frag_merger u_frag_merger (
    .clk_i(clk), .rst_ni(rst_n), .l1a_valid_i(l1a_valid), .l1a_buf_i(l1a_buf),
    .l1a_trig_i(l1a_trig), .busy_o(busy), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_rd_o(in_rd), .word_limit_i(word_limit),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready), .mismatch_o(mismatch)
  );

  initial for (int i = 0; i < N; i++) begin head[i] = 0; tail[i] = 0; end

  for (genvar g = 0; g < N; g++) begin : g_src
    assign in_valid[g]         = head[g] != tail[g];
    assign in_data[g*32 +: 32] = fmem[g][head[g] & 511];
    assign in_last[g]          = flast[g][head[g] & 511];
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n)        head[i] <= tail[i];
      else if (in_rd[i]) head[i] <= head[i] + 1;
    end
  end

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      out_ready = lfsr[0] | lfsr[3];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exv);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected output word", out_data, 32'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_last, out_data} == e, t, "record word", {out_last, out_data[30:0]}, {e[32], e[30:0]});
        if ({out_last, out_data} != e) $display("  full word actual=%h expected=%h", out_data, e[31:0]);
      end
    end
  end

  task automatic put_word(int i, logic [31:0] d, bit l);
    fmem[i][tail[i] & 511]  = d;
    flast[i][tail[i] & 511] = l;
    tail[i] = tail[i] + 1;
  endtask

  task automatic expect_word(logic [31:0] d, bit l, string t);
    exp_q.push_back({l, d});
    tag_q.push_back(t);
  endtask

  task automatic expect_header(int b, int tr, string t);
    logic [31:0] h;
    h = '0;
    h[1:0]   = 2'(b);
    h[23:16] = 8'(tr);
    expect_word(h, 1'b0, t);
  endtask

  task automatic expect_trailer(int cnt, bit to, bit mm, string t);
    logic [31:0] w;
    w = '0;
    w[15:0] = 16'(cnt);
    w[30]   = mm;
    w[31]   = to;
    expect_word(w, 1'b1, t);
  endtask

  // Loads one fragment and queues the words the block must forward
  task automatic load_frag(int i, int b, int len, int lim, bit bad, int ser, string t,
                           inout int fwd, inout bit to);
    for (int k = 0; k < len; k++) begin
      logic [31:0] d;
      if (k == 0) d = {8'(i), 8'(ser), 14'd0, 2'(bad ? (b ^ 1) : b)};
      else        d = {8'(i), 8'(ser), 16'(k)};
      put_word(i, d, k == len - 1);
      if (k < lim) begin
        expect_word(d, 1'b0, t);
        fwd++;
      end
    end
    if (len > lim) to = 1'b1;
  endtask

  task automatic push_accept(int b, int tr);
    @(posedge clk); #1;
    l1a_valid = 1'b1;
    l1a_buf   = 2'(b);
    l1a_trig  = 8'(tr);
    @(posedge clk); #1;
    l1a_valid = 1'b0;
  endtask

  task automatic full_event(int b, int tr, int l0, int l1, int l2, int bad_in, int lim,
                            int ser, string t);
    int fwd = 0;
    bit to = 1'b0;
    int lens [N];
    lens[0] = l0; lens[1] = l1; lens[2] = l2;
    expect_header(b, tr, t);
    for (int i = 0; i < N; i++) load_frag(i, b, lens[i], lim, bad_in == i, ser, t, fwd, to);
    expect_trailer(fwd, to, bad_in >= 0, t);
  endtask

  task automatic drain(string t);
    int n = 0;
    while (exp_q.size() != 0 && n < 4000) begin
      @(posedge clk);
      n++;
    end
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, t, "expected words left", 32'(exp_q.size()), 32'd0);
    check(!out_valid, t, "output quiet after record", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check({out_valid, busy, mismatch, in_rd} == '0, "R10", "outputs in reset",
          {26'd0, out_valid, busy, mismatch, in_rd}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 R2 R3 R4: plain record, extra word of the next event sits behind input 0
    full_event(1, 8'h5A, 2, 3, 1, -1, 8, 1, "R1");
    put_word(0, 32'hDEAD_0000, 1'b0);
    push_accept(1, 8'h5A);
    drain("R2");
    @(negedge clk);
    check(in_valid[0] && in_data[0 +: 32] == 32'hDEAD_0000, "R4",
          "next event word left unread", in_data[31:0], 32'hDEAD_0000);
    @(posedge clk); #1;
    head[0] = tail[0];

    // R5: mismatch on input 1, still forwarded
    full_event(2, 8'h81, 1, 1, 1, 1, 8, 2, "R5");
    push_accept(2, 8'h81);
    drain("R5");
    check(mismatch, "R5", "sticky mismatch set", {31'd0, mismatch}, 32'd1);

    // R7: stall with a presented fragment word
    begin
      int fwd = 0;
      bit to = 1'b0;
      logic [31:0] held;
      expect_header(3, 8'h3C, "R7");
      push_accept(3, 8'h3C);
      repeat (4) @(posedge clk);
      #1;
      out_ready = 1'b0;
      load_frag(0, 3, 4, 8, 1'b0, 3, "R7", fwd, to);
      @(negedge clk);
      held = out_data;
      check(out_valid && held == {8'd0, 8'd3, 14'd0, 2'd3}, "R7", "stalled word presented",
            held, {8'd0, 8'd3, 14'd0, 2'd3});
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        check(out_valid && out_data == held && in_rd == '0, "R7", "stall holds word, no read",
              {out_data[31:3], in_rd}, {held[31:3], 3'b000});
      end
      load_frag(1, 3, 2, 8, 1'b0, 3, "R7", fwd, to);
      load_frag(2, 3, 3, 8, 1'b0, 3, "R7", fwd, to);
      expect_trailer(fwd, to, 1'b0, "R7");
      @(posedge clk); #1;
      out_ready = 1'b1;
      drain("R7");
      check(mismatch, "R5", "mismatch stays high", {31'd0, mismatch}, 32'd1);
    end

    // R8 R9: fill queue under stall, drop fifth accept, drain with backpressure
    @(posedge clk); #1;
    out_ready = 1'b0;
    for (int e = 0; e < 4; e++) push_accept(e, 8'h10 + e);
    @(negedge clk);
    check(busy, "R8", "busy with full queue", {31'd0, busy}, 32'd1);
    push_accept(0, 8'hFF);
    @(negedge clk);
    check(busy, "R8", "busy after dropped accept", {31'd0, busy}, 32'd1);
    for (int e = 0; e < 4; e++)
      full_event(e, 8'h10 + e, 1 + e, 3 - (e % 3), 2, -1, 8, 16 + e, "R9");
    bp_en = 1'b1;
    drain("R8");
    bp_en = 1'b0;
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check(!busy, "R8", "busy clears after drain", {31'd0, busy}, 32'd0);

    // R6: limit 3; input 1 overruns, input 2 ends on the limit word
    word_limit = 8'd3;
    full_event(2, 8'h66, 1, 5, 3, -1, 3, 40, "R6");
    push_accept(2, 8'h66);
    drain("R6");

    // R10: reset clears the sticky flag
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({out_valid, busy, mismatch, in_rd} == '0, "R10", "outputs after second reset",
          {26'd0, out_valid, busy, mismatch, in_rd}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule